// File: doc/BRIEF.md
# Serial EEPROM Boot Copier

This block fills the bottom of a byte-wide SRAM from a serial EEPROM between reset and the first instruction fetch. While it works, it owns the SRAM address, data and write-strobe lines and keeps the processor core held. It opens an SPI-style read transaction, shifts the bytes in one bit at a time on a divided-down serial clock, and writes each completed byte to the next SRAM location, starting at address 0.

The number of bytes to copy is taken from an input that is sampled while reset is asserted. When the last byte has been stored, the block ends the serial transaction, drops its bus enable and its core-hold output, and raises a sticky done flag. The core then starts fetching from address 0, where the copied boot code now sits. A count of zero skips the copy entirely.

Top module: `eeprom_boot_copier`

## Requirements
- R1: The byte count is captured from `byte_count` while `rst_n` is low. If it is zero, `boot_done` is high in the first cycle after reset. In that case no serial clock edge and no SRAM write ever occur.
- R2: For a nonzero count, `spi_cs_n` is low from the first cycle after reset until the final byte has been written. It goes high in the same cycle that `boot_done` rises.
- R3: `spi_sck` idles low and toggles once every `CLK_DIV` system clocks. Successive rising edges within a transaction are therefore exactly 2*`CLK_DIV` system clocks apart.
- R4: The first 24 bits presented on `spi_mosi` are the read opcode 0x03 followed by a 16-bit address of 0x0000, most significant bit first. `spi_mosi` changes only while `spi_sck` is low.
- R5: After the command, `spi_miso` is sampled on each `spi_sck` rising edge. Every 8 bits form one byte, first bit in the most significant position. The cycle after the eighth rising edge, `sram_we` is high for exactly one system clock, and `sram_wdata` carries that byte.
- R6: Writes go to addresses 0, 1, 2, ... in order. The address steps by one after each write. Exactly `byte_count` writes occur.
- R7: `boot_done` rises in the cycle after the final write and stays high until the next reset.
- R8: While `boot_done` is low, `bus_en` and `core_hold` are high. Once it is high, both are low, and `sram_addr`, `sram_wdata` and `sram_we` are all zero.
- R9: During the data phase, `spi_mosi` is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_count | input | 16 | Number of bytes to copy, sampled during reset |
| spi_sck | output | 1 | Serial clock to the EEPROM |
| spi_cs_n | output | 1 | Active-low EEPROM select |
| spi_mosi | output | 1 | Command bits to the EEPROM |
| spi_miso | input | 1 | Data bits from the EEPROM |
| sram_addr | output | 16 | SRAM write address while copying |
| sram_wdata | output | 8 | Assembled byte for the SRAM |
| sram_we | output | 1 | One-cycle SRAM write strobe |
| bus_en | output | 1 | Output enable for the SRAM address, data and strobe lines |
| core_hold | output | 1 | Holds the processor core while copying |
| boot_done | output | 1 | Sticky copy-complete flag |

## Verification
Every cycle, the assertions check the following:
- the one-cycle width of the write strobe;
- the single-step address advance between writes;
- the stickiness of the done flag;
- the release of the buses, the hold and the select once copying ends;
- the serial clock staying low whenever the EEPROM is deselected.

The remaining behaviours depend on what the EEPROM returns and on absolute timing, so only the bench scenarios can show them. These are the exact command word, the bit order of assembled bytes, the serial clock period, the total number of writes and the zero-count shortcut. The bench compares each written byte and address against an EEPROM model, for several counts.

// File: rtl/eeprom_boot_copier.sv
module eeprom_boot_copier #(
  parameter int CLK_DIV = 3,
  parameter int AW      = 16,
  parameter logic [7:0] RD_OP = 8'h03
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] byte_count,
  output logic          spi_sck,
  output logic          spi_cs_n,
  output logic          spi_mosi,
  input  logic          spi_miso,
  output logic [AW-1:0] sram_addr,
  output logic [7:0]    sram_wdata,
  output logic          sram_we,
  output logic          bus_en,
  output logic          core_hold,
  output logic          boot_done
);
  localparam int DW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int CMDW = 8 + AW;

  typedef enum logic [1:0] {S_CMD, S_DATA, S_DONE} state_t;

  state_t          state;
  logic [AW-1:0]   count_q, addr_q;
  logic [DW-1:0]   div_cnt;
  logic [CMDW-1:0] cmd_sr;
  logic [5:0]      bitcnt;
  logic [7:0]      shreg;
  logic            sck_q, cs_n_q, we_q, done_q;
  logic            tick;

  assign tick = (state != S_DONE) && (div_cnt == DW'(CLK_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || state == S_DONE || tick) div_cnt <= '0;
    else                                   div_cnt <= div_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= byte_count;
      done_q  <= (byte_count == '0);
      cs_n_q  <= (byte_count == '0);
      state   <= (byte_count == '0) ? S_DONE : S_CMD;
      cmd_sr  <= {RD_OP, {AW{1'b0}}};
      sck_q   <= 1'b0;
      bitcnt  <= '0;
      shreg   <= '0;
      addr_q  <= '0;
      we_q    <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (we_q) begin
        addr_q <= addr_q + 1'b1;
        if (addr_q == count_q - 1'b1) begin
          state  <= S_DONE;
          done_q <= 1'b1;
          cs_n_q <= 1'b1;
          sck_q  <= 1'b0;
        end
      end
      if (tick && state == S_CMD) begin
        if (!sck_q) begin
          sck_q  <= 1'b1;
          bitcnt <= bitcnt + 1'b1;
        end else begin
          sck_q <= 1'b0;
          if (bitcnt == 6'(CMDW)) begin
            state  <= S_DATA;
            bitcnt <= '0;
          end else begin
            cmd_sr <= {cmd_sr[CMDW-2:0], 1'b0};
          end
        end
      end
      if (tick && state == S_DATA) begin
        if (!sck_q) begin
          sck_q <= 1'b1;
          shreg <= {shreg[6:0], spi_miso};
          if (bitcnt == 6'd7) begin
            we_q   <= 1'b1;
            bitcnt <= '0;
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end else begin
          sck_q <= 1'b0;
        end
      end
    end
  end

  assign spi_sck    = sck_q;
  assign spi_cs_n   = cs_n_q;
  assign spi_mosi   = (state == S_CMD) ? cmd_sr[CMDW-1] : 1'b0;
  assign sram_addr  = done_q ? '0 : addr_q;
  assign sram_wdata = done_q ? '0 : shreg;
  assign sram_we    = we_q;
  assign bus_en     = !done_q;
  assign core_hold  = !done_q;
  assign boot_done  = done_q;
endmodule

// File: rtl/eeprom_boot_copier_chk.sv
module eeprom_boot_copier_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          spi_sck,
  input logic          spi_cs_n,
  input logic [AW-1:0] sram_addr,
  input logic [7:0]    sram_wdata,
  input logic          sram_we,
  input logic          bus_en,
  input logic          core_hold,
  input logic          boot_done
);
  AST_WE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |=> !sram_we); // R5

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_we && !boot_done) |=> (boot_done || sram_addr == $past(sram_addr) + 1'b1)); // R6

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> boot_done); // R7

  AST_RELEASE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |-> (!bus_en && !core_hold && !sram_we && sram_addr == '0 && sram_wdata == '0)); // R8

  AST_HOLD_WHILE_COPYING: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_done |-> (bus_en && core_hold)); // R8

  AST_SELECT_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n == boot_done); // R2

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck); // R3
endmodule

bind eeprom_boot_copier eeprom_boot_copier_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
  .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_we(sram_we),
  .bus_en(bus_en), .core_hold(core_hold), .boot_done(boot_done)
);

// File: tb/sim_eeprom_boot_copier.sv
`timescale 1ns/1ps
module sim_eeprom_boot_copier;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] byte_count = '0;
  logic spi_sck, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;
  logic [15:0] sram_addr;
  logic [7:0] sram_wdata;
  logic sram_we, bus_en, core_hold, boot_done;

  int checks = 0;
  int errors = 0;

  eeprom_boot_copier #(.CLK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .byte_count(byte_count),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_we(sram_we),
    .bus_en(bus_en), .core_hold(core_hold), .boot_done(boot_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] rom_byte(input int i);
    return 8'((i * 37 + 5) ^ (i >> 2) ^ 8'hA6);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // EEPROM model
  int        rise_cnt = 0;
  logic [23:0] cmd_word = '0;
  int        mosi_bad = 0;
  int        period_bad = 0;
  realtime   last_rise = -1.0;

  always @(posedge spi_sck) begin
    if (!spi_cs_n) begin
      if (rise_cnt < 24) cmd_word = {cmd_word[22:0], spi_mosi};
      else if (spi_mosi !== 1'b0) mosi_bad++;
      if (last_rise >= 0 && ($realtime - last_rise) != 2.0 * DIV * CLK_PERIOD) period_bad++;
      last_rise = $realtime;
      rise_cnt++;
    end
  end

  always @(negedge spi_sck) begin
    if (!spi_cs_n && rise_cnt >= 24) begin
      int k;
      k = rise_cnt - 24;
      spi_miso = rom_byte(k / 8)[7 - (k % 8)];
    end
  end

  // scoreboard
  typedef struct packed { logic [15:0] a; logic [7:0] d; } wr_t;
  wr_t exp_q[$];
  int  writes_seen = 0;
  bit  expect_done_next = 0;
  bit  mon_en = 0;

  task automatic push_expected(input int n);
    exp_q.delete();
    for (int i = 0; i < n; i++) exp_q.push_back({16'(i), rom_byte(i)});
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      if (expect_done_next) begin
        chk(boot_done === 1'b1 && spi_cs_n === 1'b1, "R7/R2 done and deselect after last write", boot_done, 1);
        expect_done_next = 0;
      end
      if (sram_we === 1'b1) begin
        writes_seen++;
        if (exp_q.size() == 0) begin
          chk(0, "R6 unexpected extra write", sram_addr, 0);
        end else begin
          wr_t e;
          e = exp_q.pop_front();
          chk(sram_addr === e.a, "R6 write address", sram_addr, e.a);
          chk(sram_wdata === e.d, "R5 write data", sram_wdata, e.d);
          if (exp_q.size() == 0) expect_done_next = 1;
        end
      end
    end
  end

  task automatic do_reset(input logic [15:0] n);
    mon_en = 0;
    rst_n = 1'b0;
    byte_count = n;
    rise_cnt = 0; cmd_word = '0; mosi_bad = 0; period_bad = 0; last_rise = -1.0;
    writes_seen = 0; expect_done_next = 0;
    repeat (3) @(posedge clk);
    #1 byte_count = 16'hFFFF;
    #1 rst_n = 1'b1;
    mon_en = 1;
  endtask

  task automatic run_copy(input int n);
    int waited;
    push_expected(n);
    do_reset(16'(n));
    @(negedge clk);
    chk(boot_done === 1'b0 && core_hold === 1'b1 && bus_en === 1'b1, "R8 hold while copying", {boot_done, core_hold, bus_en}, 3'b011);
    chk(spi_cs_n === 1'b0 && spi_sck === 1'b0 && sram_addr === 16'h0, "R2 select and start address", {spi_cs_n, spi_sck, sram_addr}, 0);
    waited = 0;
    while (boot_done !== 1'b1 && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    chk(waited < 20000, "R7 copy completes", waited, 0);
    @(negedge clk);
    chk(cmd_word === 24'h030000, "R4 read command word", cmd_word, 24'h030000);
    chk(period_bad == 0, "R3 serial clock period", period_bad, 0);
    chk(mosi_bad == 0, "R9 mosi low during data", mosi_bad, 0);
    chk(writes_seen == n && exp_q.size() == 0, "R6 write count", writes_seen, n);
    chk(rise_cnt == 24 + 8 * n, "R5 data bit count", rise_cnt, 24 + 8 * n);
    chk(!bus_en && !core_hold && sram_addr === 16'h0 && sram_wdata === 8'h0 && !sram_we,
        "R8 buses released", {bus_en, core_hold, sram_addr, sram_wdata}, 0);
    repeat (20) @(negedge clk);
    chk(boot_done === 1'b1 && spi_sck === 1'b0 && writes_seen == n, "R7 done sticky, no further activity", boot_done, 1);
  endtask

  task automatic run_zero();
    push_expected(0);
    do_reset(16'h0);
    @(negedge clk);
    chk(boot_done === 1'b1, "R1 zero count done at once", boot_done, 1);
    chk(spi_cs_n === 1'b1 && !core_hold && !bus_en, "R1 zero count no hold", {spi_cs_n, core_hold, bus_en}, 3'b100);
    repeat (50) @(negedge clk);
    chk(rise_cnt == 0 && writes_seen == 0, "R1 zero count no activity", rise_cnt + writes_seen, 0);
  endtask

  initial begin
    run_copy(5);
    run_zero();
    run_copy(1);
    run_copy(19);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule